// File: doc/BRIEF.md
# General-Purpose Output Port with Set/Clear Strobes

This block is the general-purpose I/O section that all channels of a multi-channel UART share. It sits on the UART's byte-wide register bus at the global offsets, which lie above the per-channel register windows. Software never writes the output latch as a whole word. It writes a mask to the "set" offset to turn outputs on, and a mask to the "clear" offset to turn them off. Zero bits in either mask leave the matching outputs as they were, so two agents can each change their own bits without a read-modify-write race.

An output pin is active low: it drives the complement of its latch bit, so a latch bit that is on pulls the pin low. An output-routing register gives each pin a choice of source. With its bit at 0 the pin follows the latch. With its bit at 1 the pin passes an alternate signal from a UART channel through unchanged. The input pins are resynchronised into the clock domain by a flop chain and can be read at their own offset as raw levels. Because the pins are active low, the host inverts the value to get the asserted signals.

Top module: `gpio_setclr_port`

## Requirements
- R1: After a synchronous reset the output latch and the routing register are 0, every `out_pins` bit is 1, and `rd_data` is 0.
- R2: A write to offset 0xE turns on every latch bit whose `wr_data` bit is 1. Latch bits whose data bit is 0 keep their value, so a write of 0x00 changes nothing.
- R3: A write to offset 0xF turns off every latch bit whose `wr_data` bit is 1. Latch bits whose data bit is 0 keep their value.
- R4: The routing register is written and read back at offset 0xD. Where a routing bit is 0, the pin drives the inverse of its latch bit. Writing 0x00 puts every pin back under latch control.
- R5: Where a routing bit is 1, the pin copies the matching `alt_src` bit directly, whatever the latch holds.
- R6: A read at offset 0x4 returns the input pins as raw levels, with no inversion, in bits [IN_W-1:0] and 0 in the bits above. A pin change is not visible to a read that samples in the first or second clock edge after the change. It is visible from the third edge on.
- R7: `rd_data` is loaded at the clock edge where `rd_en` is sampled high, and holds its value while `rd_en` is low. A read at any offset other than 0x4 or 0xD returns 0.
- R8: Writes to offsets other than 0xD, 0xE and 0xF change neither the latch nor the routing register.
- R9: A latch write shows on `out_pins` at the clock edge that samples the write, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Global register offset |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data |
| alt_src | input | OUT_W | Alternate per-pin sources from the channels |
| in_pins | input | IN_W | Asynchronous input pins |
| out_pins | output | OUT_W | Output pins (active low when under latch control) |

## Verification
The embedded properties check on every cycle that a set write leaves all masked latch bits on, that a clear write leaves them off, and that the latch is stable whenever neither strobe is present. They also check that the synchronised input equals the pin value from the synchronizer depth earlier, and that reads at unmapped offsets return zero. The bench's directed scenarios are what show the pin-level results. These are the inverted polarity, the switch between latch control and alternate-source routing, the exact read cycle at which an input change first appears, writes to unrelated offsets having no visible effect, and read data holding between reads.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;

    localparam int BUS_W = 8;
    localparam int OFS_W = 4;

    localparam logic [OFS_W-1:0] OFS_INPUT = 4'h4;
    localparam logic [OFS_W-1:0] OFS_ROUTE = 4'hD;
    localparam logic [OFS_W-1:0] OFS_SET   = 4'hE;
    localparam logic [OFS_W-1:0] OFS_CLR   = 4'hF;

    typedef enum logic [1:0] {
        WK_NONE  = 2'd0,
        WK_SET   = 2'd1,
        WK_CLR   = 2'd2,
        WK_ROUTE = 2'd3
    } wr_kind_e;

    typedef enum logic [1:0] {
        RS_ZERO  = 2'd0,
        RS_INPUT = 2'd1,
        RS_ROUTE = 2'd2
    } rd_sel_e;

    typedef struct packed {
        wr_kind_e          kind;
        logic [BUS_W-1:0]  mask;
    } wr_cmd_t;

    typedef struct packed {
        logic     fire;
        rd_sel_e  sel;
    } rd_cmd_t;

    function automatic logic [BUS_W-1:0] apply_mask(
        input logic [BUS_W-1:0] cur,
        input wr_cmd_t          cmd
    );
        logic [BUS_W-1:0] nxt;
        case (cmd.kind)
            WK_SET:  nxt = cur | cmd.mask;
            WK_CLR:  nxt = cur & ~cmd.mask;
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/gpio_regdec.sv
module gpio_regdec
    import gpio_setclr_pkg::*;
(
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [OFS_W-1:0]  addr,
    input  logic [BUS_W-1:0]  wr_data,
    output wr_cmd_t           wcmd,
    output rd_cmd_t           rcmd
);

    always_comb begin
        wcmd.kind = WK_NONE;
        wcmd.mask = wr_data;
        if (wr_en) begin
            case (addr)
                OFS_SET:   wcmd.kind = WK_SET;
                OFS_CLR:   wcmd.kind = WK_CLR;
                OFS_ROUTE: wcmd.kind = WK_ROUTE;
                default:   wcmd.kind = WK_NONE;
            endcase
        end
    end

    always_comb begin
        rcmd.fire = rd_en;
        case (addr)
            OFS_INPUT: rcmd.sel = RS_INPUT;
            OFS_ROUTE: rcmd.sel = RS_ROUTE;
            default:   rcmd.sel = RS_ZERO;
        endcase
    end

endmodule

// File: rtl/gpio_outport.sv
module gpio_outport
    import gpio_setclr_pkg::*;
#(
    parameter int OUT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_cmd_t           wcmd,
    input  logic [OUT_W-1:0]  alt_src,
    output logic [OUT_W-1:0]  route_q,
    output logic [OUT_W-1:0]  pins
);

    logic [OUT_W-1:0] latch_q;
    logic [BUS_W-1:0] latch_ext;
    logic [BUS_W-1:0] latch_nxt;

    assign latch_ext = BUS_W'(latch_q);
    assign latch_nxt = apply_mask(latch_ext, wcmd);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            route_q <= '0;
        end else begin
            latch_q <= latch_nxt[OUT_W-1:0];
            if (wcmd.kind == WK_ROUTE)
                route_q <= wcmd.mask[OUT_W-1:0];
        end
    end

    for (genvar i = 0; i < OUT_W; i++) begin : g_pin
        assign pins[i] = route_q[i] ? alt_src[i] : ~latch_q[i];
    end

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wcmd.kind == WK_SET) |=>
            ((latch_q & $past(wcmd.mask[OUT_W-1:0])) == $past(wcmd.mask[OUT_W-1:0]))); // R2
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wcmd.kind == WK_CLR) |=> ((latch_q & $past(wcmd.mask[OUT_W-1:0])) == '0)); // R3
    AST_LATCH_IDLE: assert property (@(posedge clk) disable iff (rst)
        (wcmd.kind != WK_SET && wcmd.kind != WK_CLR) |=> $stable(latch_q)); // R8
    AST_RESET_CLEAN: assert property (@(posedge clk)
        $fell(rst) |-> (latch_q == '0 && route_q == '0)); // R1

endmodule

// File: rtl/gpio_insync.sv
module gpio_insync #(
    parameter int IN_W        = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  pins_async,
    output logic [IN_W-1:0]  pins_sync
);

    logic [IN_W-1:0] stage_q [SYNC_STAGES];

    always_ff @(posedge clk) stage_q[0] <= pins_async;

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
        always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
    end

    assign pins_sync = stage_q[SYNC_STAGES-1];

    AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (rst)
        pins_sync == $past(pins_async, SYNC_STAGES)); // R6

endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
    import gpio_setclr_pkg::*;
#(
    parameter int OUT_W       = 8,
    parameter int IN_W        = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [3:0]        addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic [OUT_W-1:0]  alt_src,
    input  logic [IN_W-1:0]   in_pins,
    output logic [OUT_W-1:0]  out_pins
);

    wr_cmd_t          wcmd;
    rd_cmd_t          rcmd;
    logic [OUT_W-1:0] route_q;
    logic [IN_W-1:0]  in_sync;

    gpio_regdec u_dec (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_data (wr_data),
        .wcmd    (wcmd),
        .rcmd    (rcmd)
    );

    gpio_outport #(.OUT_W(OUT_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .wcmd    (wcmd),
        .alt_src (alt_src),
        .route_q (route_q),
        .pins    (out_pins)
    );

    gpio_insync #(.IN_W(IN_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pins_async (in_pins),
        .pins_sync  (in_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rcmd.fire) begin
            case (rcmd.sel)
                RS_INPUT: rd_data <= BUS_W'(in_sync);
                RS_ROUTE: rd_data <= BUS_W'(route_q);
                default:  rd_data <= '0;
            endcase
        end
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr != OFS_INPUT && addr != OFS_ROUTE) |=> (rd_data == '0)); // R7
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R7

endmodule

// File: tb/gpio_setclr_port_tb.sv
module gpio_setclr_port_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, rd_en;
    logic [3:0] addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [7:0] alt_src;
    logic [6:0] in_pins;
    logic [7:0] out_pins;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] exp_latch = 8'h00;

    always #4 clk = ~clk;

    gpio_setclr_port dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .alt_src(alt_src),
        .in_pins(in_pins), .out_pins(out_pins)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 pins idle", out_pins, 8'hFF);
        chk("R1 rd_data", rd_data, 8'h00);
        bus_rd(4'hD, v);
        chk("R1 routing", v, 8'h00);
    endtask

    task automatic t_set();
        @(negedge clk);
        wr_en = 1'b1; addr = 4'hE; wr_data = 8'h05;
        #1 chk("R9 before edge", out_pins, 8'hFF);
        @(negedge clk);
        wr_en = 1'b0;
        exp_latch = 8'h05;
        chk("R9/R2 set 05", out_pins, ~exp_latch);
        bus_wr(4'hE, 8'h30); exp_latch |= 8'h30;
        chk("R2 set 30 keeps others", out_pins, ~exp_latch);
        bus_wr(4'hE, 8'h00);
        chk("R2 set 00 no change", out_pins, ~exp_latch);
    endtask

    task automatic t_clear();
        bus_wr(4'hF, 8'h11); exp_latch &= ~8'h11;
        chk("R3 clear 11", out_pins, ~exp_latch);
        bus_wr(4'hF, 8'h00);
        chk("R3 clear 00 no change", out_pins, ~exp_latch);
        bus_wr(4'hF, 8'hFF); exp_latch = 8'h00;
        chk("R3 clear all", out_pins, 8'hFF);
        bus_wr(4'hE, 8'h3C); exp_latch = 8'h3C;
        chk("R2 set 3C", out_pins, 8'hC3);
    endtask

    task automatic t_route();
        logic [7:0] v;
        alt_src = 8'h00;
        bus_wr(4'hD, 8'h81);
        chk("R5 alt low", out_pins, (~exp_latch & 8'h7E));
        @(negedge clk); alt_src = 8'hFF;
        #1 chk("R5 alt high", out_pins, (~exp_latch & 8'h7E) | 8'h81);
        bus_rd(4'hD, v);
        chk("R4 routing readback", v, 8'h81);
        bus_wr(4'hD, 8'h00);
        chk("R4 back to latch", out_pins, ~exp_latch);
    endtask

    task automatic t_ignored();
        logic [7:0] v;
        bus_wr(4'h4, 8'hFF);
        bus_wr(4'h0, 8'hFF);
        bus_wr(4'hC, 8'hFF);
        chk("R8 pins untouched", out_pins, ~exp_latch);
        bus_rd(4'hD, v);
        chk("R8 routing untouched", v, 8'h00);
    endtask

    task automatic t_input();
        logic [7:0] v;
        @(negedge clk); in_pins = 7'h00;
        repeat (3) @(negedge clk);
        in_pins = 7'h55;
        rd_en = 1'b1; addr = 4'h4;
        @(negedge clk);
        chk("R6 first edge old", rd_data, 8'h00);
        @(negedge clk);
        chk("R6 second edge old", rd_data, 8'h00);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R6 third edge new", rd_data, 8'h55);
        in_pins = 7'h7F;
        repeat (3) @(negedge clk);
        bus_rd(4'h4, v);
        chk("R6 raw level, bit7 zero", v, 8'h7F);
    endtask

    task automatic t_read_other();
        logic [7:0] v;
        bus_rd(4'hE, v);
        chk("R7 unmapped read zero", v, 8'h00);
        bus_rd(4'h4, v);
        in_pins = 7'h12;
        repeat (4) @(negedge clk);
        chk("R7 hold without rd_en", rd_data, 8'h7F);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = 4'h0;
        wr_data = 8'h00; alt_src = 8'h00; in_pins = 7'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_set();
        t_clear();
        t_route();
        t_ignored();
        t_input();
        t_read_other();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule